// File: doc/BRIEF.md
# One-Time-Programmable Row Array Command Controller

This block lets a CPU read and program a one-time-programmable row array through a small set of memory-mapped registers. Software sets an access register, loads a row address and up to 41 bits of write data, and then raises a start bit in the command register. The block runs the selected command for a fixed number of cycles. It then raises a command-done flag, which software clears by writing 1 to it. Reads copy the addressed row into two read-data registers. They also flag a parity failure of the stored row unless checking has been switched off.

Programming is locked after reset. A program-word command changes the array only after the key values 0xF, 0x4, 0x8 and 0xD have been issued in that order by consecutive program-enable commands. Once that happens, a status bit shows that the array is unlocked, and it stays unlocked until reset. The array is held as a register array whose bits can only be set: programming ORs new data into the stored row. The array is cleared only by reset, which stands for an unprogrammed part.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: After reset, status0 (offset 0x14) reads 0x8 (ready at bit 3, unlock flag at bit 2 clear), status1 (offset 0x18) reads 0, and both read-data registers (0x1C, 0x20) read 0.
- R2: A command is launched only by a 0-to-1 change of the start bit (bit 0 of the command register at 0x00) while the access-enable bit (bit 15 of the access register at 0x10) is 1. A start bit that is written while access is off, or rewritten as 1 while already 1, launches nothing.
- R3: Status0 bit 3 is 0 from the cycle after a launch until completion, and a start edge seen while busy is dropped.
- R4: Status1 bit 1 (done) is set CMD_LAT+1 clock edges after the bus write that raised the start bit. Writing 1 to it clears it and writing 0 leaves it set. A completion in the same cycle as a clearing write leaves it set.
- R5: The command code is bits [4:1] of the command register: 0 is read, 2 is program-enable and 10 is program-word. The row address is bits [15:6] of the address register (0x04), and other bits there are ignored. A read puts row bits [31:0] in read-data register 0x1C and row bits [40:32] in bits [8:0] of 0x20.
- R6: Four consecutive program-enable commands with write-data-low (0x08) values 0xF, 0x4, 0x8 and 0xD, in that order, set status0 bit 2.
- R7: A program-enable with a value that is not the next key, or any other command between keys, sends unlock progress back to the first key. Once set, the unlock flag stays set until reset.
- R8: A program-word while locked still sets done but leaves the array unchanged.
- R9: A program-word while unlocked ORs the write data into the addressed row, so bits already set stay set.
- R10: Row bits [40:32] are programmed from bits [8:0] of write-data-high (0x0C) only when access-register bit 8 is 1. Otherwise they are left as they are.
- R11: Each read sets status1 bit 17 when access-register bit 9 is 0 and the stored 41-bit row has an odd number of ones, and clears it otherwise.
- R12: A command with any other code completes with done set and changes neither the array nor the read-data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |

## Verification
Two events can fall in the same cycle: a command completing, which sets done, and a software write of 1 that clears done. The bench leaves done set from an earlier command, launches a read, and times the clearing write so that the register captures it on exactly the completion edge, CMD_LAT+1 edges after the start write. It then expects done to read 1, and a second clearing write to bring it to 0. The bench also drives a start edge while a command is in flight, and expects only one completion.

// File: rtl/otp_pkg.sv
package otp_pkg;
  // register byte offsets
  localparam logic [5:0] REG_CMD = 6'h00;
  localparam logic [5:0] REG_ROW = 6'h04;
  localparam logic [5:0] REG_WLO = 6'h08;
  localparam logic [5:0] REG_WHI = 6'h0C;
  localparam logic [5:0] REG_ACC = 6'h10;
  localparam logic [5:0] REG_ST0 = 6'h14;
  localparam logic [5:0] REG_ST1 = 6'h18;
  localparam logic [5:0] REG_RLO = 6'h1C;
  localparam logic [5:0] REG_RHI = 6'h20;

  // bit positions
  localparam int ACC_EN_BIT     = 15;
  localparam int ACC_CHKOFF_BIT = 9;
  localparam int ACC_HIWR_BIT   = 8;
  localparam int ST0_READY_BIT  = 3;
  localparam int ST0_UNLK_BIT   = 2;
  localparam int ST1_DONE_BIT   = 1;
  localparam int ST1_PERR_BIT   = 17;
  localparam int ROW_LSB        = 6;

  // command codes
  localparam logic [3:0] OP_READ     = 4'd0;
  localparam logic [3:0] OP_PGM_EN   = 4'd2;
  localparam logic [3:0] OP_PGM_WORD = 4'd10;

  // key value expected at each unlock step
  function automatic logic [31:0] unlock_key(input logic [1:0] step);
    case (step)
      2'd0:    return 32'hF;
      2'd1:    return 32'h4;
      2'd2:    return 32'h8;
      default: return 32'hD;
    endcase
  endfunction

  // true when the vector holds an odd number of ones
  function automatic logic odd_weight(input logic [63:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/otp_unlock.sv
module otp_unlock #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pe_evt,
  input  logic              other_evt,
  input  logic [DATA_W-1:0] value,
  output logic              unlocked
);
  import otp_pkg::*;

  logic [1:0] step_q;
  logic       key_hit;

  assign key_hit = (value == DATA_W'(unlock_key(step_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= 2'd0;
      unlocked <= 1'b0;
    end else if (pe_evt) begin
      if (key_hit) begin
        if (step_q == 2'd3) begin
          unlocked <= 1'b1;
          step_q   <= 2'd0;
        end else begin
          step_q <= step_q + 2'd1;
        end
      end else begin
        step_q <= 2'd0;
      end
    end else if (other_evt) begin
      step_q <= 2'd0;
    end
  end
endmodule

// File: rtl/otp_row_array.sv
module otp_row_array #(
  parameter int ROW_AW = 10,
  parameter int DATA_W = 32,
  parameter int ECC_W  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    hi_en,
  input  logic [ROW_AW-1:0]       addr,
  input  logic [DATA_W-1:0]       wr_lo,
  input  logic [ECC_W-1:0]        wr_hi,
  output logic [DATA_W+ECC_W-1:0] rd_row
);
  localparam int ROWS  = 1 << ROW_AW;
  localparam int ROW_W = DATA_W + ECC_W;

  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] set_bits;

  assign set_bits = {(hi_en ? wr_hi : {ECC_W{1'b0}}), wr_lo};
  assign rd_row   = mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= mem[addr] | set_bits;
    end
  end
endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq #(
  parameter int CMD_LAT = 4,
  parameter int CODE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rise,
  input  logic              access_en,
  input  logic [CODE_W-1:0] code_in,
  output logic              start_accept,
  output logic              ready,
  output logic              cpl_evt,
  output logic [CODE_W-1:0] cpl_code
);
  localparam int CNT_W = $clog2(CMD_LAT + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign ready        = ~busy_q;
  assign start_accept = start_rise & access_en & ~busy_q;
  assign cpl_evt      = busy_q & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      cpl_code <= '0;
    end else if (start_accept) begin
      busy_q   <= 1'b1;
      cnt_q    <= CNT_W'(CMD_LAT - 1);
      cpl_code <= code_in;
    end else if (cpl_evt) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl #(
  parameter int ROW_AW  = 10,
  parameter int DATA_W  = 32,
  parameter int ECC_W   = 9,
  parameter int CODE_W  = 4,
  parameter int CMD_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [5:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  import otp_pkg::*;

  localparam int ROW_W = DATA_W + ECC_W;

  // software-visible registers
  logic              start_q, start_prev;
  logic [CODE_W-1:0] code_q;
  logic [ROW_AW-1:0] row_q;
  logic [DATA_W-1:0] wlo_q, rlo_q;
  logic [ECC_W-1:0]  whi_q, rhi_q;
  logic              acc_en_q, chk_off_q, hi_wr_q;
  logic              done_q, perr_q;

  // operands captured at launch
  logic [ROW_AW-1:0] op_row_q;
  logic [DATA_W-1:0] op_lo_q;
  logic [ECC_W-1:0]  op_hi_q;
  logic              op_hiwr_q, op_chkoff_q;

  // named internal events
  logic              start_rise, start_accept, seq_ready, cpl_evt;
  logic [CODE_W-1:0] cpl_code;
  logic              rd_evt, pe_evt, pw_evt, other_evt, arr_we, unlocked;
  logic              clr_done;
  logic [ROW_W-1:0]  arr_row;

  assign start_rise = start_q & ~start_prev;
  assign rd_evt     = cpl_evt & (cpl_code == CODE_W'(OP_READ));
  assign pe_evt     = cpl_evt & (cpl_code == CODE_W'(OP_PGM_EN));
  assign pw_evt     = cpl_evt & (cpl_code == CODE_W'(OP_PGM_WORD));
  assign other_evt  = cpl_evt & ~pe_evt;
  assign arr_we     = pw_evt & unlocked;
  assign clr_done   = bus_wen & (bus_addr == REG_ST1) & bus_wdata[ST1_DONE_BIT];

  otp_cmd_seq #(.CMD_LAT(CMD_LAT), .CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_rise(start_rise), .access_en(acc_en_q),
    .code_in(code_q), .start_accept(start_accept), .ready(seq_ready),
    .cpl_evt(cpl_evt), .cpl_code(cpl_code)
  );

  otp_unlock #(.DATA_W(DATA_W)) u_unlock (
    .clk(clk), .rst_n(rst_n), .pe_evt(pe_evt), .other_evt(other_evt),
    .value(op_lo_q), .unlocked(unlocked)
  );

  otp_row_array #(.ROW_AW(ROW_AW), .DATA_W(DATA_W), .ECC_W(ECC_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(arr_we), .hi_en(op_hiwr_q), .addr(op_row_q),
    .wr_lo(op_lo_q), .wr_hi(op_hi_q), .rd_row(arr_row)
  );

  // register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q    <= 1'b0;
      start_prev <= 1'b0;
      code_q     <= '0;
      row_q      <= '0;
      wlo_q      <= '0;
      whi_q      <= '0;
      acc_en_q   <= 1'b0;
      chk_off_q  <= 1'b0;
      hi_wr_q    <= 1'b0;
    end else begin
      start_prev <= start_q;
      if (bus_wen) begin
        case (bus_addr)
          REG_CMD: begin
            start_q <= bus_wdata[0];
            code_q  <= bus_wdata[CODE_W:1];
          end
          REG_ROW: row_q <= bus_wdata[ROW_LSB +: ROW_AW];
          REG_WLO: wlo_q <= bus_wdata;
          REG_WHI: whi_q <= bus_wdata[ECC_W-1:0];
          REG_ACC: begin
            acc_en_q  <= bus_wdata[ACC_EN_BIT];
            chk_off_q <= bus_wdata[ACC_CHKOFF_BIT];
            hi_wr_q   <= bus_wdata[ACC_HIWR_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  // operand capture, read results and flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_row_q    <= '0;
      op_lo_q     <= '0;
      op_hi_q     <= '0;
      op_hiwr_q   <= 1'b0;
      op_chkoff_q <= 1'b0;
      rlo_q       <= '0;
      rhi_q       <= '0;
      perr_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      if (start_accept) begin
        op_row_q    <= row_q;
        op_lo_q     <= wlo_q;
        op_hi_q     <= whi_q;
        op_hiwr_q   <= hi_wr_q;
        op_chkoff_q <= chk_off_q;
      end
      if (rd_evt) begin
        rlo_q  <= arr_row[DATA_W-1:0];
        rhi_q  <= arr_row[ROW_W-1:DATA_W];
        perr_q <= ~op_chkoff_q & odd_weight(64'(arr_row));
      end
      // completion wins over a clearing write in the same cycle
      if (cpl_evt)       done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
    end
  end

  // register reads
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CMD: bus_rdata = DATA_W'({code_q, start_q});
      REG_ROW: bus_rdata = DATA_W'({row_q, {ROW_LSB{1'b0}}});
      REG_WLO: bus_rdata = wlo_q;
      REG_WHI: bus_rdata = DATA_W'(whi_q);
      REG_ACC: begin
        bus_rdata[ACC_EN_BIT]     = acc_en_q;
        bus_rdata[ACC_CHKOFF_BIT] = chk_off_q;
        bus_rdata[ACC_HIWR_BIT]   = hi_wr_q;
      end
      REG_ST0: begin
        bus_rdata[ST0_READY_BIT] = seq_ready;
        bus_rdata[ST0_UNLK_BIT]  = unlocked;
      end
      REG_ST1: begin
        bus_rdata[ST1_DONE_BIT] = done_q;
        bus_rdata[ST1_PERR_BIT] = perr_q;
      end
      REG_RLO: bus_rdata = rlo_q;
      REG_RHI: bus_rdata = DATA_W'(rhi_q);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/otp_cmd_ctrl_chk.sv
module otp_cmd_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_accept,
  input logic              cpl_evt,
  input logic [CODE_W-1:0] cpl_code,
  input logic [DATA_W-1:0] cpl_value,
  input logic              unlocked,
  input logic              ready,
  input logic              done,
  input logic              arr_we
);
  import otp_pkg::*;

  a_r4_done_after_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_evt |=> done);

  a_r3_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> !ready);

  a_r2_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> !start_accept);

  a_r6_unlock_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(cpl_evt && cpl_code == CODE_W'(OP_PGM_EN)
                              && cpl_value == DATA_W'(32'hD)));

  a_r7_unlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

  a_r8_write_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> unlocked);
endmodule

bind otp_cmd_ctrl otp_cmd_ctrl_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_accept(start_accept), .cpl_evt(cpl_evt),
  .cpl_code(cpl_code), .cpl_value(op_lo_q), .unlocked(unlocked),
  .ready(seq_ready), .done(done_q), .arr_we(arr_we)
);

// File: tb/otp_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module otp_cmd_ctrl_bench;
  localparam int LAT = 8;
  localparam logic [5:0] A_CMD = 6'h00, A_ROW = 6'h04, A_WLO = 6'h08, A_WHI = 6'h0C,
                         A_ACC = 6'h10, A_ST0 = 6'h14, A_ST1 = 6'h18, A_RLO = 6'h1C,
                         A_RHI = 6'h20;
  localparam logic [31:0] ACC_ON = 32'h8000;

  // program-then-read vectors: prog flag, row, data, hi-write, check-off, expected
  localparam int NV = 8;
  localparam logic        V_PROG [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [9:0]  V_ROW  [NV] = '{10'd3, 10'd3, 10'd3, 10'd1023, 10'd1023, 10'd0, 10'd3, 10'd2};
  localparam logic [31:0] V_LO   [NV] = '{32'hF0, 32'h0F, 32'h0, 32'h80000001, 32'h0,
                                          32'hA5A50000, 32'h0, 32'h0};
  localparam logic [8:0]  V_HI   [NV] = '{9'h1FF, 9'h003, 9'h0, 9'h100, 9'h0, 9'h001, 9'h0, 9'h0};
  localparam logic        V_HIWR [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic        V_OFF  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [31:0] E_LO   [NV] = '{32'hF0, 32'hFF, 32'hFF, 32'h80000001, 32'h80000001,
                                          32'hA5A50000, 32'hFF, 32'h0};
  localparam logic [31:0] E_HI   [NV] = '{32'h0, 32'h3, 32'h3, 32'h100, 32'h100, 32'h1, 32'h3, 32'h0};
  localparam logic        E_ERR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int checks = 0;
  int fails  = 0;
  logic [31:0] d;

  always #2 clk = ~clk;

  otp_cmd_ctrl #(.CMD_LAT(LAT)) u_otp_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  // launch a command, wait for done, optionally clear done, drop start
  task automatic run_cmd(input logic [3:0] code, input bit clear);
    logic [31:0] s;
    bit seen = 0;
    wr(A_CMD, {27'd0, code, 1'b0});
    wr(A_CMD, {27'd0, code, 1'b1});
    for (int n = 0; n < 60 && !seen; n++) begin
      rd(A_ST1, s);
      if (s[1]) seen = 1;
      else @(negedge clk);
    end
    chk("R4 command reaches done", {31'd0, seen}, 32'd1);
    if (clear) wr(A_ST1, 32'h2);
    wr(A_CMD, {27'd0, code, 1'b0});
  endtask

  task automatic load(input logic [9:0] row, input logic [31:0] lo, input logic [8:0] hi);
    wr(A_ROW, {16'd0, row, 6'h2A});
    wr(A_WLO, lo);
    wr(A_WHI, {23'd0, hi});
  endtask

  task automatic pe(input logic [31:0] v);
    wr(A_WLO, v);
    run_cmd(4'd2, 1'b1);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_ST0, d); chk("R1 status0 after reset", d, 32'h8);
    rd(A_ST1, d); chk("R1 status1 after reset", d, 32'h0);
    rd(A_RLO, d); chk("R1 read-data low after reset", d, 32'h0);
    rd(A_RHI, d); chk("R1 read-data high after reset", d, 32'h0);

    // R2 start with access off does nothing
    wr(A_CMD, 32'h1);
    repeat (LAT + 6) @(negedge clk);
    rd(A_ST1, d); chk("R2 no done with access off", d, 32'h0);
    rd(A_ST0, d); chk("R2 still ready with access off", d, 32'h8);
    wr(A_CMD, 32'h0);
    wr(A_ACC, ACC_ON);

    // R8 program-word while locked
    load(10'd5, 32'hFFFF, 9'h1FF);
    wr(A_ACC, ACC_ON | 32'h100);
    run_cmd(4'd10, 1'b1);
    wr(A_ROW, {16'd0, 10'd5, 6'd0});
    run_cmd(4'd0, 1'b1);
    rd(A_RLO, d); chk("R8 locked program leaves row low", d, 32'h0);
    rd(A_RHI, d); chk("R8 locked program leaves row high", d, 32'h0);

    // R7 broken sequences
    pe(32'hF); pe(32'h4); pe(32'h7); pe(32'h8); pe(32'hD);
    rd(A_ST0, d); chk("R7 wrong key resets progress", d, 32'h8);
    pe(32'hF); pe(32'h4); run_cmd(4'd0, 1'b1); pe(32'h8); pe(32'hD);
    rd(A_ST0, d); chk("R7 read between keys resets progress", d, 32'h8);

    // R6 good sequence
    pe(32'hF); pe(32'h4); pe(32'h8);
    rd(A_ST0, d); chk("R6 not unlocked before last key", d, 32'h8);
    pe(32'hD);
    rd(A_ST0, d); chk("R6 unlocked after key sequence", d, 32'hC);
    pe(32'h1);
    rd(A_ST0, d); chk("R7 unlock flag sticky", d, 32'hC);

    // R5 R9 R10 R11 vector table
    for (int i = 0; i < NV; i++) begin
      if (V_PROG[i]) begin
        load(V_ROW[i], V_LO[i], V_HI[i]);
        wr(A_ACC, ACC_ON | {22'd0, V_OFF[i], V_HIWR[i], 8'd0});
        run_cmd(4'd10, 1'b1);
      end
      wr(A_ROW, {16'd0, V_ROW[i], 6'h15});
      wr(A_ACC, ACC_ON | {22'd0, V_OFF[i], V_HIWR[i], 8'd0});
      run_cmd(4'd0, 1'b1);
      rd(A_RLO, d); chk($sformatf("R5/R9/R10 vector %0d low", i), d, E_LO[i]);
      rd(A_RHI, d); chk($sformatf("R5/R9/R10 vector %0d high", i), d, E_HI[i]);
      rd(A_ST1, d); chk($sformatf("R11 vector %0d check flag", i), d, {14'd0, E_ERR[i], 17'd0});
    end
    wr(A_ACC, ACC_ON);

    // R4 exact latency, R3 ready low while busy
    wr(A_ROW, {16'd0, 10'd3, 6'd0});
    wr(A_CMD, 32'h0);
    wr(A_CMD, 32'h1);
    @(negedge clk);
    rd(A_ST0, d); chk("R3 not ready while busy", d[3], 1'b0);
    repeat (LAT - 1) @(negedge clk);
    rd(A_ST1, d); chk("R4 done not yet at CMD_LAT edges", d[1], 1'b0);
    @(negedge clk);
    rd(A_ST1, d); chk("R4 done at CMD_LAT+1 edges", d[1], 1'b1);
    rd(A_ST0, d); chk("R3 ready after completion", d[3], 1'b1);
    wr(A_ST1, 32'h0);
    rd(A_ST1, d); chk("R4 writing 0 keeps done", d[1], 1'b1);
    wr(A_ST1, 32'h2);
    rd(A_ST1, d); chk("R4 writing 1 clears done", d[1], 1'b0);

    // R3 start edge while busy is dropped
    wr(A_CMD, 32'h0);
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h0);
    wr(A_CMD, 32'h1);
    repeat (LAT + 4) @(negedge clk);
    rd(A_ST1, d); chk("R3 first command completes", d[1], 1'b1);
    wr(A_ST1, 32'h2);
    repeat (LAT + 6) @(negedge clk);
    rd(A_ST1, d); chk("R3 edge while busy gave no command", d[1], 1'b0);

    // R2 start held high launches nothing new
    wr(A_CMD, 32'h1);
    repeat (LAT + 6) @(negedge clk);
    rd(A_ST1, d); chk("R2 held start launches nothing", d[1], 1'b0);
    wr(A_CMD, 32'h0);

    // R4 collision: completion and clearing write on the same edge
    run_cmd(4'd0, 1'b0);
    wr(A_CMD, 32'h1);
    repeat (LAT - 1) @(negedge clk);
    wr(A_ST1, 32'h2);
    rd(A_ST1, d); chk("R4 completion beats clearing write", d[1], 1'b1);
    wr(A_ST1, 32'h2);
    rd(A_ST1, d); chk("R4 clear after collision", d[1], 1'b0);
    wr(A_CMD, 32'h0);

    // R12 unknown code
    wr(A_ROW, {16'd0, 10'd2, 6'd0});
    wr(A_WLO, 32'hFFFF_FFFF);
    run_cmd(4'd5, 1'b1);
    rd(A_RLO, d); chk("R12 unknown code keeps read data", d, 32'hFF);
    run_cmd(4'd0, 1'b1);
    rd(A_RLO, d); chk("R12 unknown code leaves array", d, 32'h0);

    summary();
    $finish;
  end
endmodule